// File: doc/BRIEF.md
# SCSI Target Phase and Handshake Engine

This block sits on the target side of a parallel SCSI bus and is steered by firmware through a small byte-wide register window. Firmware sets the control lines the target owns by writing a single line mask. It reads back the synchronized state of the lines the initiator owns, and it moves data through two byte registers: one for the byte driven onto the bus and one for the byte captured from it.

In manual mode, firmware runs every REQ/ACK handshake itself through the mask. In automatic mode, the hardware runs the handshake for a programmed number of bytes. A pacing output tells a slow host, such as one behind a serial link, when the next byte may be written or read. When sending, each byte written starts one handshake. When receiving, each read of the capture register starts the next handshake. Received bytes reach the host through a short delay line, so the host throws away its first few reads after enabling.

Top module: `scsi_tgt_engine`

## Requirements
- R1: After reset all target-driven lines and the data-bus enable are low, the pacing output is high, and the mask, transfer count and data registers read zero.
- R2: In manual mode (mask bit 0 clear), each target line follows its mask bit: bit 7 BSY, bit 6 SEL, bit 5 C/D, bit 4 I/O, bit 3 MSG, bit 2 REQ, bit 1 RST. The mask is written and read at offset 1.
- R3: Offset 0 reads the initiator-side lines after the input synchronizer: bit 7 BSY, bit 6 SEL, bit 5 ACK, bit 4 ATN, bit 3 RST, bits 2..0 zero.
- R4: The data bus is enabled only while mask bits 7 (BSY) and 4 (I/O) are both set, and it then carries the byte written at offset 3.
- R5: When the bus is not driven, the data byte is captured on the rising edge of the synchronized ACK, and offset 2 returns it. An ACK edge while the target drives the bus leaves the captured byte unchanged.
- R6: The transfer count is written and read as a high byte at offset 4 and a low byte at offset 5. It decreases by one each time an automatic handshake completes, which happens when ACK is released.
- R7: With bit 0 and I/O set (send), a write to offset 3 raises REQ. REQ drops after ACK is seen. Pacing stays low from the write until ACK is released, then returns high.
- R8: With bit 0 set and I/O clear (receive), setting bit 0 starts the first handshake. Each later read of offset 2 starts the next one while the count is non-zero. Pacing goes high once each byte has completed.
- R9: In receive mode, read n of offset 2 after enabling returns received byte n-3. The first three reads return zero.
- R10: Once the count reaches zero, REQ is not raised again. Reloading the count has no effect until bit 0 is cleared and set again.
- R11: In automatic mode, mask bit 2 has no effect on REQ. Clearing bit 0 during a handshake drops REQ at once and leaves the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (acts on offset 2) |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rd_data | output | 8 | Read data for reg_addr |
| bsy_in | input | 1 | BSY line as seen on the bus |
| sel_in | input | 1 | SEL line as seen on the bus |
| ack_in | input | 1 | ACK from the initiator |
| atn_in | input | 1 | ATN from the initiator |
| rst_in | input | 1 | Bus reset line |
| db_in | input | 8 | Data bus as seen on the bus |
| bsy_out | output | 1 | Target BSY drive |
| sel_out | output | 1 | Target SEL drive |
| cd_out | output | 1 | Target C/D drive |
| io_out | output | 1 | Target I/O drive |
| msg_out | output | 1 | Target MSG drive |
| req_out | output | 1 | Target REQ drive |
| rst_out | output | 1 | Target bus-reset drive |
| db_out | output | 8 | Data driven onto the bus |
| db_oe | output | 1 | Data bus output enable |
| pace | output | 1 | High when the host may supply or collect the next byte |

## Verification
The embedded assertions check on every cycle that:
- REQ rises only while a non-zero count remains.
- REQ falls in the cycle after ACK is seen.
- REQ stays low while automatic mode is off.
- The count changes only by a register write or a single decrement.
- In manual mode, REQ and the data-bus enable rise only after a mask write.

Only the bench scenarios can show the following:
- The bit positions of the mask and line-status fields.
- The three-read delay of the receive path with its leading zeros.
- That a reloaded count stays idle until bit 0 is toggled.
- That a captured byte survives an ACK edge while the target drives the bus.

// File: rtl/scsi_tgt_pkg.sv
`timescale 1ns/1ps
package scsi_tgt_pkg;

    typedef enum logic [1:0] {
        HS_IDLE = 2'd0,
        HS_REQ  = 2'd1,
        HS_REL  = 2'd2
    } hs_state_e;

    // register offsets
    localparam logic [2:0] OFS_LINES  = 3'd0;
    localparam logic [2:0] OFS_MASK   = 3'd1;
    localparam logic [2:0] OFS_CAP    = 3'd2;
    localparam logic [2:0] OFS_DOUT   = 3'd3;
    localparam logic [2:0] OFS_CNT_HI = 3'd4;
    localparam logic [2:0] OFS_CNT_LO = 3'd5;

    // mask bit positions
    localparam int M_BSY  = 7;
    localparam int M_SEL  = 6;
    localparam int M_CD   = 5;
    localparam int M_IO   = 4;
    localparam int M_MSG  = 3;
    localparam int M_REQ  = 2;
    localparam int M_RST  = 1;
    localparam int M_AUTO = 0;

endpackage

// File: rtl/scsi_tgt_sync.sv
`timescale 1ns/1ps
module scsi_tgt_sync #(
    parameter int WIDTH  = 13,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0][WIDTH-1:0] stg_d, stg_q;

    always_comb begin
        stg_d    = stg_q;
        stg_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= stg_d;
    end

    assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/scsi_tgt_hshake.sv
`timescale 1ns/1ps
module scsi_tgt_hshake
    import scsi_tgt_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int PIPE_DEPTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             auto_en,
    input  logic             send_mode,
    input  logic             data_wr,
    input  logic             cap_rd,
    input  logic             cnt_wr_hi,
    input  logic             cnt_wr_lo,
    input  logic [7:0]       wdata,
    input  logic             ack_s,
    input  logic [7:0]       cap_byte,
    output logic             req_o,
    output logic             pace_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic [7:0]       tail_o
);
    localparam int HI_W = CNT_W - 8;
    localparam logic [CNT_W-1:0] ONE = 1;

    typedef struct packed {
        hs_state_e                  st;
        logic [CNT_W-1:0]           cnt;
        logic                       armed;
        logic                       auto_prev;
        logic [PIPE_DEPTH-1:0][7:0] pipe;
    } eng_s;

    eng_s q, n;
    logic auto_rise, rx_mode, pop, kick, armed_now;

    always_comb begin
        n         = q;
        auto_rise = auto_en & ~q.auto_prev;
        rx_mode   = auto_en & ~send_mode;
        pop       = cap_rd & rx_mode;
        armed_now = q.armed | auto_rise;
        kick      = auto_en & (send_mode ? data_wr : (auto_rise | pop));

        n.auto_prev = auto_en;
        if (auto_rise) n.armed = 1'b1;

        if (pop) begin
            for (int i = PIPE_DEPTH - 1; i > 0; i--) begin
                n.pipe[i] = q.pipe[i-1];
            end
            n.pipe[0] = cap_byte;
        end
        if (auto_rise) n.pipe = '0;

        unique case (q.st)
            HS_IDLE: if (kick && armed_now && q.cnt != '0) n.st = HS_REQ;
            HS_REQ:  if (ack_s) n.st = HS_REL;
            HS_REL: begin
                if (!ack_s) begin
                    n.st  = HS_IDLE;
                    n.cnt = q.cnt - ONE;
                    if (q.cnt == ONE) n.armed = 1'b0;
                end
            end
            default: n.st = HS_IDLE;
        endcase

        if (!auto_en) n.st = HS_IDLE;

        if (cnt_wr_hi) n.cnt[CNT_W-1:8] = wdata[HI_W-1:0];
        if (cnt_wr_lo) n.cnt[7:0]       = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st        <= HS_IDLE;
            q.cnt       <= '0;
            q.armed     <= 1'b0;
            q.auto_prev <= 1'b0;
            q.pipe      <= '0;
        end else begin
            q <= n;
        end
    end

    assign req_o  = (q.st == HS_REQ);
    assign pace_o = (q.st == HS_IDLE);
    assign cnt_o  = q.cnt;
    assign tail_o = q.pipe[PIPE_DEPTH-1];

    assert_req_needs_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_o) |-> $past(q.cnt) != '0);

    assert_req_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == HS_REQ && ack_s) |=> !req_o);

    assert_no_req_manual_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_en |=> !req_o);

    assert_cnt_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cnt != $past(q.cnt)) && !$past(cnt_wr_hi || cnt_wr_lo)
        |-> q.cnt == $past(q.cnt) - ONE);
endmodule

// File: rtl/scsi_tgt_engine.sv
`timescale 1ns/1ps
module scsi_tgt_engine
    import scsi_tgt_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int PIPE_DEPTH  = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [2:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rd_data,
    input  logic       bsy_in,
    input  logic       sel_in,
    input  logic       ack_in,
    input  logic       atn_in,
    input  logic       rst_in,
    input  logic [7:0] db_in,
    output logic       bsy_out,
    output logic       sel_out,
    output logic       cd_out,
    output logic       io_out,
    output logic       msg_out,
    output logic       req_out,
    output logic       rst_out,
    output logic [7:0] db_out,
    output logic       db_oe,
    output logic       pace
);
    localparam int SW = 13;

    typedef struct packed {
        logic [7:0] mask;
        logic [7:0] dout;
        logic [7:0] cap;
        logic       ack_prev;
    } top_s;

    top_s q, n;

    logic [SW-1:0]    sync_out;
    logic             bsy_s, sel_s, ack_s, atn_s, rst_s;
    logic [7:0]       db_s;
    logic             eng_req, eng_pace;
    logic [CNT_W-1:0] eng_cnt;
    logic [7:0]       eng_tail;
    logic             driving, auto_on, rx_view;

    scsi_tgt_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({bsy_in, sel_in, ack_in, atn_in, rst_in, db_in}),
        .sync_o  (sync_out)
    );
    assign {bsy_s, sel_s, ack_s, atn_s, rst_s, db_s} = sync_out;

    assign auto_on = q.mask[M_AUTO];
    assign driving = q.mask[M_IO] & q.mask[M_BSY];
    assign rx_view = auto_on & ~q.mask[M_IO];

    scsi_tgt_hshake #(.CNT_W(CNT_W), .PIPE_DEPTH(PIPE_DEPTH)) u_hs (
        .clk       (clk),
        .rst_n     (rst_n),
        .auto_en   (auto_on),
        .send_mode (q.mask[M_IO]),
        .data_wr   (reg_wr && reg_addr == OFS_DOUT),
        .cap_rd    (reg_rd && reg_addr == OFS_CAP),
        .cnt_wr_hi (reg_wr && reg_addr == OFS_CNT_HI),
        .cnt_wr_lo (reg_wr && reg_addr == OFS_CNT_LO),
        .wdata     (reg_wdata),
        .ack_s     (ack_s),
        .cap_byte  (q.cap),
        .req_o     (eng_req),
        .pace_o    (eng_pace),
        .cnt_o     (eng_cnt),
        .tail_o    (eng_tail)
    );

    always_comb begin
        n          = q;
        n.ack_prev = ack_s;
        if (ack_s && !q.ack_prev && !driving) n.cap = db_s;
        if (reg_wr) begin
            if (reg_addr == OFS_MASK) n.mask = reg_wdata;
            if (reg_addr == OFS_DOUT) n.dout = reg_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    always_comb begin
        unique case (reg_addr)
            OFS_LINES:  reg_rd_data = {bsy_s, sel_s, ack_s, atn_s, rst_s, 3'b000};
            OFS_MASK:   reg_rd_data = q.mask;
            OFS_CAP:    reg_rd_data = rx_view ? eng_tail : q.cap;
            OFS_DOUT:   reg_rd_data = q.dout;
            OFS_CNT_HI: reg_rd_data = eng_cnt[CNT_W-1:8];
            OFS_CNT_LO: reg_rd_data = eng_cnt[7:0];
            default:    reg_rd_data = 8'h00;
        endcase
    end

    assign bsy_out = q.mask[M_BSY];
    assign sel_out = q.mask[M_SEL];
    assign cd_out  = q.mask[M_CD];
    assign io_out  = q.mask[M_IO];
    assign msg_out = q.mask[M_MSG];
    assign rst_out = q.mask[M_RST];
    assign req_out = auto_on ? eng_req : q.mask[M_REQ];
    assign db_out  = q.dout;
    assign db_oe   = driving;
    assign pace    = eng_pace;

    assert_manual_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(req_out) && !auto_on) |-> $past(reg_wr && reg_addr == OFS_MASK));

    assert_oe_from_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(db_oe) |-> $past(reg_wr && reg_addr == OFS_MASK));
endmodule

// File: tb/test_scsi_tgt_engine.sv
`timescale 1ns/1ps
module test_scsi_tgt_engine;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rd_data;
    logic       bsy_in = 0, sel_in = 0, ack_in = 0, atn_in = 0, rst_in = 0;
    logic [7:0] db_in = '0;
    logic       bsy_out, sel_out, cd_out, io_out, msg_out, req_out, rst_out;
    logic [7:0] db_out;
    logic       db_oe, pace;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    scsi_tgt_engine i_scsi_tgt_engine (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rd_data(reg_rd_data),
        .bsy_in(bsy_in), .sel_in(sel_in), .ack_in(ack_in), .atn_in(atn_in),
        .rst_in(rst_in), .db_in(db_in), .bsy_out(bsy_out), .sel_out(sel_out),
        .cd_out(cd_out), .io_out(io_out), .msg_out(msg_out), .req_out(req_out),
        .rst_out(rst_out), .db_out(db_out), .db_oe(db_oe), .pace(pace)
    );

    // {mask, expected {bsy,sel,cd,io,msg,req,rst,oe}}
    localparam logic [15:0] MVEC [0:8] = '{
        16'h80_80, 16'h40_40, 16'h20_20, 16'h10_10, 16'h90_91,
        16'h08_08, 16'h04_04, 16'h02_02, 16'hFE_FF
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 v = reg_rd_data;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // initiator side of one handshake; checks REQ drop while ACK held
    task automatic ack_cycle(input logic [7:0] d, input string tag);
        db_in = d; ack_in = 1'b1;
        settle(5);
        check({tag, " req low after ack"}, {15'd0, req_out}, 16'd0);
        check({tag, " pace low during ack"}, {15'd0, pace}, 16'd0);
        ack_in = 1'b0;
        settle(5);
        check({tag, " pace high after release"}, {15'd0, pace}, 16'd1);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [7:0] v;
        logic [7:0] rxb [1:4];
        rxb[1] = 8'h31; rxb[2] = 8'h32; rxb[3] = 8'h33; rxb[4] = 8'h34;

        settle(4);
        rst_n = 1'b1;
        settle(1);
        // R1 reset state
        check("R1 outputs", {8'd0, bsy_out, sel_out, cd_out, io_out, msg_out, req_out, rst_out, db_oe}, 16'd0);
        check("R1 pace", {15'd0, pace}, 16'd1);
        rd(3'd1, v); check("R1 mask", {8'd0, v}, 16'd0);
        rd(3'd5, v); check("R1 count", {8'd0, v}, 16'd0);
        rd(3'd3, v); check("R1 dout", {8'd0, v}, 16'd0);

        // R2/R4 mask table
        foreach (MVEC[i]) begin
            wr(3'd1, MVEC[i][15:8]);
            settle(1);
            check($sformatf("R2 mask %h", MVEC[i][15:8]),
                  {8'd0, bsy_out, sel_out, cd_out, io_out, msg_out, req_out, rst_out, db_oe},
                  {8'd0, MVEC[i][7:0]});
        end
        rd(3'd1, v); check("R2 mask readback", {8'd0, v}, 16'h00FE);

        // R4 driven data
        wr(3'd3, 8'hC3);
        wr(3'd1, 8'h90);
        settle(1);
        check("R4 db_out", {7'd0, db_oe, db_out}, 16'h01C3);

        // R3 line status
        bsy_in = 1; atn_in = 1;
        settle(4);
        rd(3'd0, v); check("R3 bsy+atn", {8'd0, v}, 16'h0090);
        bsy_in = 0; atn_in = 0; sel_in = 1; ack_in = 1; rst_in = 1;
        settle(4);
        rd(3'd0, v); check("R3 sel+ack+rst", {8'd0, v}, 16'h0068);
        sel_in = 0; ack_in = 0; rst_in = 0;
        settle(4);

        // R5 capture, ignored while driving
        wr(3'd1, 8'h00);
        db_in = 8'h5A; ack_in = 1; settle(5); ack_in = 0; settle(5);
        rd(3'd2, v); check("R5 capture", {8'd0, v}, 16'h005A);
        wr(3'd1, 8'h90);
        db_in = 8'h11; ack_in = 1; settle(5); ack_in = 0; settle(5);
        rd(3'd2, v); check("R5 no capture while driving", {8'd0, v}, 16'h005A);

        // R6 count registers
        wr(3'd4, 8'h01); wr(3'd5, 8'h02);
        rd(3'd4, v); check("R6 count hi", {8'd0, v}, 16'h0001);
        rd(3'd5, v); check("R6 count lo", {8'd0, v}, 16'h0002);

        // R7 automatic send of two bytes
        wr(3'd4, 8'h00);
        wr(3'd1, 8'h91);
        settle(2);
        check("R7 pace idle", {15'd0, pace}, 16'd1);
        wr(3'd3, 8'hA1);
        check("R7 req+data after write", {7'd0, req_out, db_out}, 16'h01A1);
        check("R7 pace low after write", {15'd0, pace}, 16'd0);
        ack_cycle(8'h00, "R7 b1");
        rd(3'd5, v); check("R6 count after 1", {8'd0, v}, 16'h0001);
        wr(3'd3, 8'hA2);
        check("R7 second req", {15'd0, req_out}, 16'd1);
        ack_cycle(8'h00, "R7 b2");
        rd(3'd5, v); check("R6 count at zero", {8'd0, v}, 16'h0000);

        // R10 no REQ at zero, no restart on reload alone
        wr(3'd3, 8'hA3); settle(3);
        check("R10 no req at zero", {15'd0, req_out}, 16'd0);
        wr(3'd5, 8'h03);
        wr(3'd3, 8'hA4); settle(3);
        check("R10 reload without toggle", {15'd0, req_out}, 16'd0);
        wr(3'd1, 8'h90); wr(3'd1, 8'h91);
        wr(3'd3, 8'hA5);
        check("R10 restart after toggle", {15'd0, req_out}, 16'd1);

        // R11 abort and REQ bit ignored
        wr(3'd1, 8'h90); settle(1);
        check("R11 abort drops req", {14'd0, req_out, pace}, 16'd1);
        rd(3'd5, v); check("R11 count kept", {8'd0, v}, 16'h0003);
        wr(3'd1, 8'h95); settle(2);
        check("R11 mask req ignored", {15'd0, req_out}, 16'd0);

        // R8/R9 automatic receive of four bytes
        wr(3'd1, 8'h80);
        wr(3'd5, 8'h04);
        wr(3'd1, 8'h81);
        settle(2);
        for (int k = 1; k <= 7; k++) begin
            if (k <= 4) begin
                check($sformatf("R8 req for byte %0d", k), {15'd0, req_out}, 16'd1);
                ack_cycle(rxb[k], "R8 rx");
                rd(3'd5, v);
                check($sformatf("R6 rx count %0d", k), {8'd0, v}, 16'(4 - k));
            end
            rd(3'd2, v);
            check($sformatf("R9 read %0d", k), {8'd0, v},
                  (k <= 3) ? 16'd0 : {8'd0, rxb[k-3]});
            settle(1);
        end
        check("R10 rx stops at zero", {15'd0, req_out}, 16'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule